// File: doc/BRIEF.md
# Interval Timer with Split Period Registers

This block is a down-counting interval timer that sits on a simple synchronous register port. Software loads a period as two half-width words; every such write also reloads the live counter with the full period. When the control word enables it, the counter steps down by a fixed amount each clock and stops at zero instead of wrapping. On reaching zero it reloads from the period and sets a timeout flag. The interrupt line is high while that flag and the interrupt-enable control bit are both set. Software clears the flag by writing the status word.

The live count can be sampled at any moment through a pair of capture registers. A read of either one latches the whole count and returns the requested half. With continuous mode off, a running counter stops once it has reloaded to the period value. A counter freshly loaded by a period write therefore stays still until continuous mode is turned on.

Top module: `ivtimer`

## Requirements
- R1: The word index is the byte address shifted right by two: 0 status, 1 control, 2 period bits 15:0, 3 period bits 31:16, 4 capture of count bits 15:0, 5 capture of count bits 31:16. Read data appears on `bus_rdata` one clock after the read is presented and holds until the next read.
- R2: Status reads return the timeout flag in bit 0 and the running indication in bit 1. Control reads return its four bits in 3:0. All other bits of both words read zero.
- R3: Status bit 1 is read-only and reads as start AND NOT stop. Writing either value to it has no effect.
- R4: A write to index 2 or 3 replaces that half of the 32-bit period. The counter is loaded with the resulting full period on the same edge.
- R5: The counter changes only while control bit 2 (start) is 1 and bit 3 (stop) is 0. With bit 1 (continuous) at 0, it holds whenever the count equals the period.
- R6: Each active clock lowers the count by STEP (default 2). A count of STEP or less goes to zero, never below.
- R7: When an active clock brings the count to zero, the counter reloads from the period on that same edge and status bit 0 is set. A status write on that same edge does not prevent the set.
- R8: `irq` is high exactly when control bit 0 (interrupt enable) and status bit 0 are both 1.
- R9: A write to status loads bit 0 of the write data into the timeout flag, so writing 0 clears a pending interrupt.
- R10: A read of index 4 or 5 returns the half of the count as it stood before that edge's update.
- R11: A read of index 6 or above returns zero. A write to such an index changes nothing.
- R12: A period write on the same edge as an active clock wins: the counter takes the new period, and there is no decrement and no timeout on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address within the block |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one clock after the read |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, 16-bit registers, a 5-bit address and a step of two. With these values the odd-period saturation case and the address indices 6 and 7 (beyond the six registers) are reachable. Most periods written are below 40, so expiry, reload and flag clearing occur hundreds of times in the random phase. Occasional nonzero upper halves cover loading and capturing full 32-bit counts.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
   localparam int NUM_REGS = 6;
   localparam int CTRL_W   = 4;

   typedef enum logic [2:0] {
      IX_STATUS  = 3'd0,
      IX_CTRL    = 3'd1,
      IX_PER_LO  = 3'd2,
      IX_PER_HI  = 3'd3,
      IX_SNAP_LO = 3'd4,
      IX_SNAP_HI = 3'd5
   } reg_ix_e;

   // control bit positions
   localparam int CB_IEN   = 0;
   localparam int CB_CONT  = 1;
   localparam int CB_START = 2;
   localparam int CB_STOP  = 3;
endpackage

// File: rtl/ivt_counter.sv
module ivt_counter #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 32,
   parameter int STEP   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              per_wr_lo,
   input  logic              per_wr_hi,
   input  logic [DATA_W-1:0] wdata,
   input  logic              run,
   input  logic              cont,
   output logic [CNT_W-1:0]  period,
   output logic [CNT_W-1:0]  count,
   output logic              expire
);
   localparam int NHALF = CNT_W / DATA_W;

   logic [NHALF-1:0] half_wr;
   logic [CNT_W-1:0] period_q, period_next, count_q, dec;
   logic             load, hold, tick;

   assign half_wr = NHALF'({per_wr_hi, per_wr_lo});
   assign load    = |half_wr;

   for (genvar h = 0; h < NHALF; h++) begin : g_half
      always_ff @(posedge clk) begin
         if (!rst_n)          period_q[h*DATA_W +: DATA_W] <= '0;
         else if (half_wr[h]) period_q[h*DATA_W +: DATA_W] <= wdata;
      end
      assign period_next[h*DATA_W +: DATA_W] = half_wr[h] ? wdata : period_q[h*DATA_W +: DATA_W];
   end

   assign hold   = !cont && (count_q == period_q);
   assign tick   = run && !hold && !load;
   assign dec    = (count_q > CNT_W'(STEP)) ? count_q - CNT_W'(STEP) : '0;
   assign expire = tick && (dec == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)      count_q <= '0;
      else if (load)   count_q <= period_next;
      else if (expire) count_q <= period_q;
      else if (tick)   count_q <= dec;
   end

   assign period = period_q;
   assign count  = count_q;

   p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> count_q == period_q);
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> $stable(count_q));
   p_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !expire) |=> count_q < $past(count_q));
endmodule

// File: rtl/ivt_ctrl.sv
module ivt_ctrl
   import ivt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic              status_wr,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   input  logic              to_wdata,
   input  logic              expire,
   output logic [CTRL_W-1:0] ctrl,
   output logic              to_flag
);
   always_ff @(posedge clk) begin
      if (!rst_n)       ctrl <= '0;
      else if (ctrl_wr) ctrl <= ctrl_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         to_flag <= 1'b0;
      else if (expire)    to_flag <= 1'b1;
      else if (status_wr) to_flag <= to_wdata;
   end

   p_to_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> to_flag);
   p_to_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (status_wr && !to_wdata && !expire) |=> !to_flag);
endmodule

// File: rtl/ivt_rdport.sv
module ivt_rdport
   import ivt_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 16,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] word_off,
   input  logic              run,
   input  logic              to_flag,
   input  logic [CTRL_W-1:0] ctrl,
   input  logic [CNT_W-1:0]  period,
   input  logic [CNT_W-1:0]  count,
   output logic [DATA_W-1:0] rdata
);
   logic [CNT_W-1:0]  snap_q;
   logic [DATA_W-1:0] rdata_q, word;
   logic              sel_snap_q, sel_hi_q, is_snap;

   assign is_snap = (word_off == ADDR_W'(IX_SNAP_LO)) || (word_off == ADDR_W'(IX_SNAP_HI));

   always_comb begin
      word = '0;
      if (word_off == ADDR_W'(IX_STATUS))      word = {{(DATA_W-2){1'b0}}, run, to_flag};
      else if (word_off == ADDR_W'(IX_CTRL))   word = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
      else if (word_off == ADDR_W'(IX_PER_LO)) word = period[DATA_W-1:0];
      else if (word_off == ADDR_W'(IX_PER_HI)) word = period[CNT_W-1:DATA_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap_q     <= '0;
         rdata_q    <= '0;
         sel_snap_q <= 1'b0;
         sel_hi_q   <= 1'b0;
      end else if (rd_en) begin
         rdata_q    <= word;
         sel_snap_q <= is_snap;
         sel_hi_q   <= (word_off == ADDR_W'(IX_SNAP_HI));
         if (is_snap) snap_q <= count;
      end
   end

   assign rdata = sel_snap_q ? (sel_hi_q ? snap_q[CNT_W-1:DATA_W] : snap_q[DATA_W-1:0]) : rdata_q;

   p_oor_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && word_off >= ADDR_W'(NUM_REGS)) |=> rdata == '0);
   p_snap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && word_off == ADDR_W'(IX_SNAP_LO)) |=> rdata == $past(count[DATA_W-1:0]));
endmodule

// File: rtl/ivtimer.sv
module ivtimer
   import ivt_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 16,
   parameter int CNT_W  = 32,
   parameter int STEP   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   if (CNT_W != 2 * DATA_W) begin : g_bad_width
      $error("CNT_W must be twice DATA_W");
   end
   if (DATA_W < CTRL_W) begin : g_bad_data
      $error("DATA_W too narrow for control word");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W cannot reach six word registers");
   end
   if (STEP < 1) begin : g_bad_step
      $error("STEP must be positive");
   end

   logic [ADDR_W-1:0] word_off;
   logic [CNT_W-1:0]  period, count;
   logic [CTRL_W-1:0] ctrl;
   logic              expire, to_flag, run;

   assign word_off = bus_addr >> 2;
   assign run      = ctrl[CB_START] && !ctrl[CB_STOP];

   ivt_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W), .STEP(STEP)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .per_wr_lo (bus_wr && word_off == ADDR_W'(IX_PER_LO)),
      .per_wr_hi (bus_wr && word_off == ADDR_W'(IX_PER_HI)),
      .wdata     (bus_wdata),
      .run       (run),
      .cont      (ctrl[CB_CONT]),
      .period    (period),
      .count     (count),
      .expire    (expire)
   );

   ivt_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_wr    (bus_wr && word_off == ADDR_W'(IX_CTRL)),
      .status_wr  (bus_wr && word_off == ADDR_W'(IX_STATUS)),
      .ctrl_wdata (bus_wdata[CTRL_W-1:0]),
      .to_wdata   (bus_wdata[0]),
      .expire     (expire),
      .ctrl       (ctrl),
      .to_flag    (to_flag)
   );

   ivt_rdport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (bus_rd),
      .word_off (word_off),
      .run      (run),
      .to_flag  (to_flag),
      .ctrl     (ctrl),
      .period   (period),
      .count    (count),
      .rdata    (bus_rdata)
   );

   assign irq = ctrl[CB_IEN] && to_flag;

   p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(expire) || $past(bus_wr));
endmodule

// File: tb/ivtimer_test.sv
`timescale 1ns/1ps
module ivtimer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq;

   int n_run = 0, n_fail = 0;

   logic [31:0] m_period = '0, m_count = '0;
   logic [3:0]  m_ctrl = '0;
   logic        m_to = 1'b0;
   logic [15:0] m_rd = '0;

   always #5 clk = ~clk;

   ivtimer uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
                .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

   function automatic logic [15:0] read_word(input logic [2:0] ix);
      logic run;
      run = m_ctrl[2] & ~m_ctrl[3];
      case (ix)
         3'd0:    return {14'd0, run, m_to};
         3'd1:    return {12'd0, m_ctrl};
         3'd2:    return m_period[15:0];
         3'd3:    return m_period[31:16];
         3'd4:    return m_count[15:0];
         3'd5:    return m_count[31:16];
         default: return 16'd0;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input logic wr, input logic rd, input logic [4:0] a,
                       input logic [15:0] d, input string req);
      logic [2:0]  ix;
      logic [31:0] np, nc;
      logic        ld, ex, run;
      ix = a[4:2];
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      if (rd) m_rd = read_word(ix);
      ld = wr && (ix == 3'd2 || ix == 3'd3);
      np = m_period;
      if (wr && ix == 3'd2) np[15:0] = d;
      if (wr && ix == 3'd3) np[31:16] = d;
      run = m_ctrl[2] & ~m_ctrl[3];
      ex = 1'b0;
      nc = m_count;
      if (ld) nc = np;
      else if (run && !(!m_ctrl[1] && m_count == m_period)) begin
         nc = (m_count > 32'd2) ? m_count - 32'd2 : 32'd0;
         if (nc == 32'd0) begin nc = m_period; ex = 1'b1; end
      end
      if (ex) m_to = 1'b1;
      else if (wr && ix == 3'd0) m_to = d[0];
      if (wr && ix == 3'd1) m_ctrl = d[3:0];
      m_period = np;
      m_count = nc;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      if (rd) check({req, " rdata"}, {16'd0, bus_rdata}, {16'd0, m_rd});
      check({req, " irq"}, {31'd0, irq}, {31'd0, m_ctrl[0] & m_to});
   endtask

   task automatic idle(input int n, input string req);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 5'd0, 16'd0, req);
   endtask

   initial begin
      #2000000;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state R1 R2
      check("R8 reset irq", {31'd0, irq}, 32'd0);
      step(1'b0, 1'b1, 5'd0, 16'd0, "R2 reset status");
      step(1'b0, 1'b1, 5'd4, 16'd0, "R1 reset ctrl");
      step(1'b0, 1'b1, 5'd8, 16'd0, "R1 reset period");
      // control readback masks R2
      step(1'b1, 1'b0, 5'd4, 16'hFFF5, "R2 ctrl write");
      step(1'b0, 1'b1, 5'd4, 16'd0, "R2 ctrl mask");
      step(1'b1, 1'b0, 5'd4, 16'h0000, "R2 ctrl clear");
      // period halves and reload R4 R10
      step(1'b1, 1'b0, 5'd8, 16'd10, "R4 per lo");
      step(1'b0, 1'b1, 5'd16, 16'd0, "R10 snap lo");
      step(1'b1, 1'b0, 5'd12, 16'd1, "R4 per hi");
      step(1'b0, 1'b1, 5'd12, 16'd0, "R4 per hi read");
      step(1'b0, 1'b1, 5'd20, 16'd0, "R10 snap hi");
      step(1'b0, 1'b1, 5'd16, 16'd0, "R10 snap lo 2");
      step(1'b1, 1'b0, 5'd12, 16'd0, "R4 per hi zero");
      // continuous run, expiry R6 R7 R8
      step(1'b1, 1'b0, 5'd8, 16'd6, "R4 per 6");
      step(1'b1, 1'b0, 5'd4, 16'h0007, "R5 start cont ien");
      for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 5'd16, 16'd0, "R7 count down");
      step(1'b0, 1'b1, 5'd0, 16'd0, "R3 running bit");
      // status bit1 ignored, bit0 clears R3 R9
      step(1'b1, 1'b0, 5'd0, 16'h0002, "R9 clear to");
      step(1'b0, 1'b1, 5'd0, 16'd0, "R3 ro bit");
      // odd period saturation R6
      step(1'b1, 1'b0, 5'd8, 16'd5, "R6 per 5");
      for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 5'd16, 16'd0, "R6 saturate");
      // stop bit R5
      step(1'b1, 1'b0, 5'd4, 16'h000F, "R5 stop");
      for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 5'd16, 16'd0, "R5 held");
      // one-shot: run partway then drop continuous R5
      step(1'b1, 1'b0, 5'd4, 16'h0007, "R5 restart");
      step(1'b1, 1'b0, 5'd4, 16'h0005, "R5 one shot");
      for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 5'd16, 16'd0, "R5 one shot hold");
      // period write while running R12
      step(1'b1, 1'b0, 5'd4, 16'h0007, "R12 cont");
      idle(1, "R12 tick");
      step(1'b1, 1'b0, 5'd8, 16'd20, "R12 load wins");
      step(1'b0, 1'b1, 5'd16, 16'd0, "R12 after load");
      // same-edge expiry vs status clear R7
      step(1'b1, 1'b0, 5'd8, 16'd2, "R7 per 2");
      step(1'b1, 1'b0, 5'd0, 16'h0000, "R7 expire beats clear");
      // out of range R11
      step(1'b1, 1'b0, 5'd24, 16'hFFFF, "R11 write 6");
      step(1'b1, 1'b0, 5'd28, 16'hFFFF, "R11 write 7");
      step(1'b0, 1'b1, 5'd24, 16'd0, "R11 read 6");
      step(1'b0, 1'b1, 5'd28, 16'd0, "R11 read 7");
      step(1'b0, 1'b1, 5'd4, 16'd0, "R11 ctrl intact");
      step(1'b0, 1'b1, 5'd8, 16'd0, "R11 period intact");
      // random phase R1..R12
      for (int i = 0; i < 3000; i++) begin
         int unsigned op;
         logic [4:0] a;
         op = $urandom % 10;
         a = 5'($urandom % 32);
         case (op)
            4: step(1'b0, 1'b1, a, 16'd0, "R1 rand read");
            5: step(1'b1, 1'b0, 5'd8, 16'($urandom % 40), "R4 rand lo");
            6: step(1'b1, 1'b0, 5'd12, ($urandom % 8 == 0) ? 16'($urandom) : 16'd0, "R4 rand hi");
            7: step(1'b1, 1'b0, 5'd4, 16'($urandom), "R5 rand ctrl");
            8: step(1'b1, 1'b0, 5'd0, 16'($urandom), "R9 rand status");
            9: step(1'b0, 1'b1, ($urandom % 2) ? 5'd16 : 5'd20, 16'd0, "R10 rand snap");
            default: step(1'b0, 1'b0, 5'd0, 16'd0, "R8 rand idle");
         endcase
      end
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule